// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 32-bit virtual address into a 32-bit physical address for a machine whose address space is divided into segments, and each segment is split into fixed 4 KB pages. The upper 4 bits of the virtual address pick one of 16 segments. The next 16 bits pick a page inside that segment. The low 12 bits are the byte offset and pass through unchanged. A segment table base address, given on an input and latched when a request is accepted, locates a table of 64-bit segment descriptors. Each descriptor has a valid flag, read/write/execute permissions, a bound counted in pages, and the byte address of the page table for that segment. It carries no base address.

A translation takes two reads in sequence on a single memory read port. The first read fetches the segment descriptor. The block then checks the valid flag, the bound and the access permission. If all three pass, a second read fetches the page entry, which holds a valid flag and a frame number. The response returns either the physical address or a fault code. Only one translation is in flight at a time. Requests and responses each use a valid/ready handshake.

Top module: `seg_page_xlate`

## Requirements
- R1: On success the response has fault code 0, and the physical address is the 20-bit frame number from the page entry followed by the unchanged 12-bit offset.
- R2: The first read targets base + 8 × segment number. In that 64-bit descriptor, bit 63 is valid, bit 62 allows read, bit 61 allows write and bit 60 allows execute. Bits 48:32 are the bound in pages, and bits 31:0 are the page table byte address.
- R3: When the descriptor checks pass, a second read targets page table address + 8 × page number. In that page entry, bit 63 is valid and bits 19:0 are the frame number. A successful translation makes exactly two reads.
- R4: A descriptor with bit 63 clear gives fault code 1 after exactly one read.
- R5: A page number greater than or equal to the bound gives fault code 2 after exactly one read. A bound of zero therefore rejects every page.
- R6: The access type is encoded 0 = read, 1 = write, 2 = execute and 3 = reserved. An access without its permission bit set, or any reserved access, gives fault code 3 after exactly one read.
- R7: A page entry with bit 63 clear gives fault code 4 after two reads.
- R8: When several faults apply, the reported code follows this priority: segment invalid (1), then bound (2), then protection (3), then page invalid (4).
- R9: Whenever the fault code is nonzero, the physical address in the response is zero.
- R10: req_ready is high only while no translation is in progress. A response held by rsp_ready low keeps its physical address and fault code unchanged.
- R11: mem_req stays high with a stable mem_addr until the cycle in which mem_rvalid is seen.
- R12: rsp_valid rises in the cycle right after the data for the last read returns.
- R13: After reset, req_ready is 1 and both rsp_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_tbl_base | input | 32 | Byte address of the segment table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and able to accept a request |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req | output | 1 | Read request to table memory |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | 64 | Read data word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pa | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 3 | Fault code 0 to 4 |

## Verification
The response is due in the cycle right after the last read's data pulse. The bench records the cycle count at which its memory model raises mem_rvalid and compares it with the cycle in which rsp_valid is first seen. Read addresses are compared in the cycle the data is returned. The number of reads is counted per translation: one when the fault is found at the descriptor, two otherwise. All outputs are sampled on the falling clock edge. Back-pressure cases hold rsp_ready low for several cycles and check that the response and req_ready stay steady before release. After release, the bench checks that the block is idle again one edge later.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_SEG   = 3'd1,
    FLT_BOUND = 3'd2,
    FLT_PROT  = 3'd3,
    FLT_PAGE  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PTE  = 2'd2,
    ST_RESP = 2'd3
  } walk_st_e;

  // table word layout (64-bit entries, 8-byte stride)
  localparam int unsigned TBL_DW     = 64;
  localparam int unsigned TBL_STRIDE = 3;
  localparam int unsigned DSC_V_BIT  = 63;
  localparam int unsigned DSC_R_BIT  = 62;
  localparam int unsigned DSC_W_BIT  = 61;
  localparam int unsigned DSC_X_BIT  = 60;
  localparam int unsigned DSC_BND_LO = 32;
  localparam int unsigned DSC_BND_W  = 17;
  localparam int unsigned PTE_V_BIT  = 63;
endpackage

// File: rtl/spx_rst_sync.sv
module spx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spx_seg_check.sv
module spx_seg_check
  import spx_pkg::*;
#(
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned AW     = 32
) (
  input  logic [TBL_DW-1:0] dsc,
  input  logic [PAGE_W-1:0] page,
  input  acc_e              acc,
  output fault_e            fault,
  output logic [AW-1:0]     pt_base
);
  localparam int unsigned PAD_W = DSC_BND_W - PAGE_W;

  logic [DSC_BND_W-1:0] bound;
  logic [DSC_BND_W-1:0] page_ext;
  logic                 perm;

  assign bound    = dsc[DSC_BND_LO +: DSC_BND_W];
  assign page_ext = {{PAD_W{1'b0}}, page};
  assign pt_base  = dsc[AW-1:0];

  always_comb begin
    unique case (acc)
      ACC_READ:  perm = dsc[DSC_R_BIT];
      ACC_WRITE: perm = dsc[DSC_W_BIT];
      ACC_EXEC:  perm = dsc[DSC_X_BIT];
      default:   perm = 1'b0;
    endcase
  end

  // priority: invalid segment, bound, protection
  always_comb begin
    if (!dsc[DSC_V_BIT])       fault = FLT_SEG;
    else if (page_ext >= bound) fault = FLT_BOUND;
    else if (!perm)            fault = FLT_PROT;
    else                       fault = FLT_NONE;
  end
endmodule

// File: rtl/spx_pte_form.sv
module spx_pte_form
  import spx_pkg::*;
#(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned OFF_W   = 12
) (
  input  logic [TBL_DW-1:0]        pte,
  input  logic [OFF_W-1:0]         offset,
  output fault_e                   fault,
  output logic [FRAME_W+OFF_W-1:0] pa
);
  assign fault = pte[PTE_V_BIT] ? FLT_NONE : FLT_PAGE;
  assign pa    = pte[PTE_V_BIT] ? {pte[FRAME_W-1:0], offset} : '0;
endmodule

// File: rtl/spx_walk_ctrl.sv
module spx_walk_ctrl
  import spx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rvalid,
  input  logic seg_ok,
  input  logic rsp_ready,
  output logic req_ready,
  output logic mem_req,
  output logic in_seg,
  output logic rsp_valid,
  output logic ld_req,
  output logic ld_seg,
  output logic ld_pte
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid)  st_d = ST_SEG;
      ST_SEG:  if (mem_rvalid) st_d = seg_ok ? ST_PTE : ST_RESP;
      ST_PTE:  if (mem_rvalid) st_d = ST_RESP;
      ST_RESP: if (rsp_ready)  st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready = (st_q == ST_IDLE);
  assign in_seg    = (st_q == ST_SEG);
  assign mem_req   = (st_q == ST_SEG) || (st_q == ST_PTE);
  assign rsp_valid = (st_q == ST_RESP);
  assign ld_req    = req_ready && req_valid;
  assign ld_seg    = in_seg && mem_rvalid;
  assign ld_pte    = (st_q == ST_PTE) && mem_rvalid;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned AW     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 seg_tbl_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_va,
  input  logic [1:0]                    req_acc,
  output logic                          mem_req,
  output logic [AW-1:0]                 mem_addr,
  input  logic                          mem_rvalid,
  input  logic [63:0]                   mem_rdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [PA_W-1:0]               rsp_pa,
  output logic [2:0]                    rsp_fault
);
  localparam int unsigned VA_W    = SEG_W + PAGE_W + OFF_W;
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic rst_i_n;
  logic in_seg, ld_req, ld_seg, ld_pte, seg_ok;

  logic [VA_W-1:0] va_q, va_d;
  acc_e            acc_q, acc_d;
  logic [AW-1:0]   stb_q, stb_d;
  logic [AW-1:0]   ptb_q, ptb_d;
  logic [PA_W-1:0] pa_q, pa_d;
  fault_e          flt_q, flt_d;

  logic [SEG_W-1:0]  va_seg;
  logic [PAGE_W-1:0] va_page;
  logic [OFF_W-1:0]  va_off;
  fault_e            seg_flt, pte_flt;
  logic [AW-1:0]     seg_ptb;
  logic [PA_W-1:0]   pte_pa;

  assign {va_seg, va_page, va_off} = va_q;

  spx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  spx_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .req_valid(req_valid), .mem_rvalid(mem_rvalid),
    .seg_ok(seg_ok), .rsp_ready(rsp_ready), .req_ready(req_ready),
    .mem_req(mem_req), .in_seg(in_seg), .rsp_valid(rsp_valid),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_pte(ld_pte)
  );

  spx_seg_check #(.PAGE_W(PAGE_W), .AW(AW)) u_seg (
    .dsc(mem_rdata), .page(va_page), .acc(acc_q), .fault(seg_flt), .pt_base(seg_ptb)
  );

  spx_pte_form #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_pte (
    .pte(mem_rdata), .offset(va_off), .fault(pte_flt), .pa(pte_pa)
  );

  assign seg_ok = (seg_flt == FLT_NONE);

  // read address: descriptor or page entry, 8-byte stride
  always_comb begin
    if (in_seg) mem_addr = stb_q + (AW'(va_seg) << TBL_STRIDE);
    else        mem_addr = ptb_q + (AW'(va_page) << TBL_STRIDE);
  end

  always_comb begin
    va_d  = va_q;
    acc_d = acc_q;
    stb_d = stb_q;
    ptb_d = ptb_q;
    pa_d  = pa_q;
    flt_d = flt_q;
    if (ld_req) begin
      va_d  = req_va;
      acc_d = acc_e'(req_acc);
      stb_d = seg_tbl_base;
    end
    if (ld_seg) begin
      ptb_d = seg_ptb;
      flt_d = seg_flt;
      pa_d  = '0;
    end
    if (ld_pte) begin
      flt_d = pte_flt;
      pa_d  = pte_pa;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      va_q  <= va_d;
      acc_q <= acc_d;
      stb_q <= stb_d;
    end
    if (ld_seg) ptb_q <= ptb_d;
    if (ld_seg || ld_pte) begin
      pa_q  <= pa_d;
      flt_q <= flt_d;
    end
  end

  assign rsp_pa    = pa_q;
  assign rsp_fault = flt_q;
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic [2:0]  rsp_fault
);
  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid)); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault))); // R10

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R11

  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == 32'd0)); // R9

  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4)); // R8

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rvalid && mem_req)); // R12
endmodule

bind seg_page_xlate seg_page_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/seg_page_xlate_tb_top.sv
module seg_page_xlate_tb_top;
  localparam logic [31:0] STB   = 32'h0000_8000;
  localparam logic [31:0] PTREG = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, mem_req, rsp_valid;
  logic [31:0] mem_addr, rsp_pa;
  logic [2:0] rsp_fault;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rv_cyc = 0;
  int reads = 0;
  int rd_total = 0;
  int wait_cnt = 0;
  logic [31:0] prev_addr = '0;
  logic prev_wait = 1'b0;
  int cur_s = 0;
  int cur_p = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  seg_page_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .seg_tbl_base(STB), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // table contents, computed arithmetically
  function automatic int s_bound(int s);
    return (s == 11) ? 0 : (s * 5 + 2) % 23;
  endfunction
  function automatic bit s_valid(int s);
    return !(s == 5 || s == 13);
  endfunction
  function automatic logic [63:0] dsc_word(int s);
    logic [63:0] w;
    w = '0;
    w[63] = s_valid(s);
    w[62] = s[0] | s[3];
    w[61] = s[1];
    w[60] = s[2];
    w[48:32] = 17'(s_bound(s));
    w[31:0] = PTREG + (32'(s) << 20);
    return w;
  endfunction
  function automatic bit p_valid(int s, int p);
    return ((p + s) % 7) != 3;
  endfunction
  function automatic logic [19:0] p_frame(int s, int p);
    return 20'((s * 4099 + p * 37 + 1) & 32'hFFFFF);
  endfunction
  function automatic logic [63:0] pte_word(int s, int p);
    logic [63:0] w;
    w = 64'hDEAD_0000_0000_0000 & 64'h0FFF_0000_0000_0000;
    w[63] = p_valid(s, p);
    w[19:0] = p_frame(s, p);
    return w;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: responds on falling edges with latency 0..2
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      wait_cnt = 0;
      prev_wait = 1'b0;
    end else if (mem_req) begin
      if (prev_wait) chk(mem_addr == prev_addr, "R11 address held", mem_addr, prev_addr);
      prev_addr = mem_addr;
      if (wait_cnt >= (rd_total % 3)) begin
        if (reads == 0) begin
          chk(mem_addr == STB + 32'(cur_s * 8), "R2 descriptor address", mem_addr, STB + 32'(cur_s * 8));
          mem_rdata = dsc_word(cur_s);
        end else begin
          chk(mem_addr == PTREG + (32'(cur_s) << 20) + 32'(cur_p * 8), "R3 page entry address",
              mem_addr, PTREG + (32'(cur_s) << 20) + 32'(cur_p * 8));
          mem_rdata = pte_word(cur_s, cur_p);
        end
        mem_rvalid = 1'b1;
        reads++;
        rd_total++;
        rv_cyc = cyc;
      end else begin
        wait_cnt++;
        prev_wait = 1'b1;
      end
    end else begin
      prev_wait = 1'b0;
    end
  end

  task automatic xlate(input int s, input int p, input int acc, input int hold);
    int off;
    int ef;
    int nconds;
    longint epa;
    int erd;
    int rcyc;
    int t;
    bit perm;
    logic [2:0] f0;
    logic [31:0] pa0;
    string tag;
    off = (s * 291 + p * 13 + acc * 1000) & 12'hFFF;
    perm = (acc == 0) ? (s[0] | s[3]) : (acc == 1) ? s[1] : (acc == 2) ? s[2] : 1'b0;
    nconds = 0;
    if (!s_valid(s)) nconds++;
    if (p >= s_bound(s)) nconds++;
    if (!perm) nconds++;
    if (!s_valid(s)) ef = 1;
    else if (p >= s_bound(s)) ef = 2;
    else if (!perm) ef = 3;
    else if (!p_valid(s, p)) ef = 4;
    else ef = 0;
    erd = (ef == 0 || ef == 4) ? 2 : 1;
    epa = (ef == 0) ? longint'({p_frame(s, p), 12'(off)}) : 0;
    case (ef)
      0: tag = "R1"; 1: tag = "R4"; 2: tag = "R5"; 3: tag = "R6"; default: tag = "R7";
    endcase
    if (nconds > 1) tag = "R8";
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle before request", req_ready, 1);
    cur_s = s; cur_p = p; reads = 0;
    req_va = {4'(s), 16'(p), 12'(off)};
    req_acc = 2'(acc);
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 60) begin
      @(negedge clk);
      t++;
    end
    rcyc = cyc;
    chk(rsp_valid == 1'b1, "R10 response arrives", rsp_valid, 1);
    chk(rsp_fault == 3'(ef), {tag, " fault code"}, rsp_fault, ef);
    chk(rsp_pa == 32'(epa), (ef != 0) ? "R9 zero address on fault" : "R1 physical address", rsp_pa, epa);
    chk(reads == erd, (erd == 2) ? "R3 two reads" : {tag, " single read"}, reads, erd);
    chk(rcyc == rv_cyc + 1, "R12 response timing", rcyc, rv_cyc + 1);
    if (hold > 0) begin
      f0 = rsp_fault; pa0 = rsp_pa;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(rsp_valid && !req_ready && rsp_fault == f0 && rsp_pa == pa0, "R10 held response",
            {rsp_valid, req_ready, rsp_fault}, {1'b1, 1'b0, f0});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 idle after release", {rsp_valid, req_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R13 reset state",
        {req_ready, rsp_valid, mem_req}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R13 state after release",
        {req_ready, rsp_valid, mem_req}, 3'b100);
    for (int s = 0; s < 16; s++) begin
      for (int a = 0; a < 4; a++) begin
        int b;
        b = s_bound(s);
        xlate(s, 0, a, 0);
        xlate(s, 1, a, 0);
        xlate(s, (b + 65535) & 16'hFFFF, a, 0);
        xlate(s, b, a, (a == 1) ? 3 : 0);
        xlate(s, b + 7, a, 0);
        xlate(s, 16'hFFFF, a, 0);
        xlate(s, (b > 3) ? 3 : 0, a, (a == 2) ? 2 : 0);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule